// File: doc/BRIEF.md
# Taken-Branch Target Line Cache

This block is a small, fully associative store of instruction bytes. Each entry holds the first 16-byte line found at the target of a recently taken branch. When the predictor marks a branch taken, the decode stage presents the computed target address on the lookup port. On a hit, the block returns the stored line in the same cycle, so the instruction buffer can be loaded without waiting for an instruction-cache access. On a miss, the front end takes the normal fetch path and pays the extra cycle.

When the line fetched from the target returns, the front end offers it on the fill port together with its address. The block then writes it into the entry that already holds that address. If no entry holds it, the block writes it into the lowest-numbered free entry. If every entry is in use, it replaces the entry chosen by a round-robin pointer. A flush input empties the whole cache in one cycle, for example after code has been modified or the context has changed.

Top module: `taken_target_cache`

## Requirements
- R1: After reset no entry is valid, and every lookup reports a miss until a fill has been accepted.
- R2: A lookup whose 32-bit address equals the tag of a valid entry raises `lk_hit` in the same cycle and drives that entry's 128-bit line on `lk_data`. At most one entry ever matches.
- R3: While `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high. While `lk_valid` is low, both are low. `lk_data` is all zeros whenever `lk_hit` is low.
- R4: A fill that is accepted on a clock edge is visible to lookups from the next cycle on. A lookup in the same cycle as the fill still sees the earlier contents.
- R5: A fill whose address is already held overwrites that entry's line and does not create a second entry for the same address.
- R6: A fill of a new address, made while some entry is invalid, uses the lowest-numbered invalid entry. The replacement pointer does not move.
- R7: A fill of a new address, made while all 16 entries are valid, replaces the entry at the replacement pointer. The pointer is 0 after reset and after a flush, and it advances by one, modulo 16, after each such replacement.
- R8: A flush invalidates every entry in one cycle and returns the replacement pointer to 0. A fill in the same cycle as a flush is discarded.
- R9: Tags compare all 32 address bits, so addresses that differ in any single bit never alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request for a predicted-taken target |
| lk_addr | input | 32 | Target address to look up |
| lk_hit | output | 1 | Lookup found the target line (same cycle) |
| lk_miss | output | 1 | Lookup missed; use the normal fetch path |
| lk_data | output | 128 | Line held for the target, zero on a miss |
| fill_valid | input | 1 | Fetched target line offered for capture |
| fill_addr | input | 32 | Address of the offered line |
| fill_data | input | 128 | 16 bytes of instructions from that address |
| flush | input | 1 | Invalidate all entries |

## Verification
Lookup results are combinational, so `lk_hit`, `lk_miss` and `lk_data` are due in the same cycle as the request. The bench drives its inputs at the falling edge and samples the outputs 2 ns later, before the next rising edge. Fills and flushes take effect at the next rising edge. For that reason the bench's reference model applies each cycle's fill or flush only after it has checked that cycle's lookup. A lookup made together with a fill is therefore checked against the old contents, and the lookup in the following cycle is checked against the new ones.

// File: rtl/ttc_pkg.sv
// Package for the taken-target line cache.
// Holds the default geometry and the encoding of the write action that one
// fill can cause. Assumes nothing beyond a single clock domain.
package ttc_pkg;
    localparam int TTC_ENTRIES    = 16;
    localparam int TTC_ADDR_W     = 32;
    localparam int TTC_LINE_BYTES = 16;

    // What an accepted fill does to the tag array.
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,   // no write this cycle
        WR_UPDATE = 2'd1,   // address already present: overwrite in place
        WR_FREE   = 2'd2,   // new address placed in the lowest invalid entry
        WR_EVICT  = 2'd3    // new address replaces the round-robin victim
    } wr_kind_e;
endpackage

// File: rtl/ttc_tag_match.sv
// Fully associative tag comparator for the taken-target line cache.
// Compares one address against every valid tag and returns the match vector,
// an any-match flag and the index of the matching entry.
// Assumes at most one valid entry holds a given tag, so the match vector is
// one-hot or zero and an OR-reduction of indices is enough to encode it.
module ttc_tag_match #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              addr,
    output logic [ENTRIES-1:0]             match,
    output logic                           any,
    output logic [IDX_W-1:0]               idx
);
    // Per-entry comparator, one per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == addr);
    end

    // Encode the one-hot match into an entry index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

    // Flag any hit.
    assign any = |match;
endmodule

// File: rtl/ttc_victim_sel.sv
// Victim selection for the taken-target line cache.
// Picks the lowest-numbered invalid entry when one exists. Otherwise it
// points at the round-robin pointer supplied by the caller, who also owns
// that pointer's advance. Pure combinational logic.
module ttc_victim_sel #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic               have_free,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] free_idx;

    // Priority search for the lowest invalid entry; scanning down leaves the lowest.
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    // Free entry first, round-robin victim otherwise.
    assign victim_idx = have_free ? free_idx : rr_ptr;
endmodule

// File: rtl/ttc_line_store.sv
// Line storage for the taken-target line cache.
// One 16-byte register row per entry, written on a single port and read
// combinationally on a single port. Rows are not reset: the caller gates
// every read with its own valid bits.
module ttc_line_store #(
    parameter int ENTRIES = 16,
    parameter int LINE_W  = 128,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_data
);
    logic [LINE_W-1:0] row_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_row
        // Capture a new line into this row when it is addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) row_q[g] <= wr_data;
        end
    end

    // Same-cycle read of the selected row.
    assign rd_data = row_q[rd_idx];
endmodule

// File: rtl/taken_target_cache.sv
// Taken-branch target line cache (top).
// Looks up predicted-taken target addresses against a fully associative tag
// array and returns the stored 16-byte line in the same cycle. Fills update a
// matching entry in place, or else take the lowest free entry, or else evict
// round-robin. A flush clears all entries and the pointer in one cycle and
// wins over a fill in the same cycle.
// Assumes a single clock and a synchronous active-low reset.
module taken_target_cache
    import ttc_pkg::*;
#(
    parameter int ENTRIES    = TTC_ENTRIES,
    parameter int ADDR_W     = TTC_ADDR_W,
    parameter int LINE_BYTES = TTC_LINE_BYTES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [ADDR_W-1:0]       lk_addr,
    output logic                    lk_hit,
    output logic                    lk_miss,
    output logic [LINE_BYTES*8-1:0] lk_data,
    input  logic                    fill_valid,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [LINE_BYTES*8-1:0] fill_data,
    input  logic                    flush
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [IDX_W-1:0]               rr_q;

    logic [ENTRIES-1:0] lk_match_vec;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic [ENTRIES-1:0] fill_match_vec;
    logic               fill_any;
    logic [IDX_W-1:0]   fill_idx;
    logic               have_free;
    logic [IDX_W-1:0]   victim_idx;
    logic [LINE_W-1:0]  rd_line;

    wr_kind_e         wr_kind;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_en;

    ttc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_match (
        .valid (valid_q),
        .tags  (tag_q),
        .addr  (lk_addr),
        .match (lk_match_vec),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    ttc_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fill_match (
        .valid (valid_q),
        .tags  (tag_q),
        .addr  (fill_addr),
        .match (fill_match_vec),
        .any   (fill_any),
        .idx   (fill_idx)
    );

    ttc_victim_sel #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid      (valid_q),
        .rr_ptr     (rr_q),
        .have_free  (have_free),
        .victim_idx (victim_idx)
    );

    ttc_line_store #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (fill_data),
        .rd_idx  (lk_idx),
        .rd_data (rd_line)
    );

    // Classify the fill: update in place, fill a free slot, or evict.
    always_comb begin
        wr_kind = WR_NONE;
        wr_idx  = '0;
        if (fill_valid && !flush) begin
            if (fill_any) begin
                wr_kind = WR_UPDATE;
                wr_idx  = fill_idx;
            end else begin
                wr_kind = have_free ? WR_FREE : WR_EVICT;
                wr_idx  = victim_idx;
            end
        end
    end

    assign wr_en = (wr_kind != WR_NONE);

    // Valid bits and replacement pointer, with reset and flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            if (wr_kind == WR_EVICT) rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
        end
    end

    // Tag capture; tags need no reset because they are qualified by the valid bits.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= fill_addr;
    end

    // Lookup response, produced in the same cycle as the request.
    assign lk_hit  = lk_valid && lk_any;
    assign lk_miss = lk_valid && !lk_any;
    assign lk_data = lk_hit ? rd_line : '0;
endmodule

// File: rtl/ttc_checker.sv
// Assertion checker for the taken-target line cache, bound into the top.
// Observes the ports plus the lookup match vector and the replacement pointer.
module ttc_checker #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int LINE_W  = 128,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [ADDR_W-1:0]  lk_addr,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic [LINE_W-1:0]  lk_data,
    input logic               fill_valid,
    input logic [ADDR_W-1:0]  fill_addr,
    input logic [LINE_W-1:0]  fill_data,
    input logic               flush,
    input logic [ENTRIES-1:0] lk_match,
    input logic [IDX_W-1:0]   rr_ptr
);
    // R2: no two entries ever answer the same lookup.
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $onehot0(lk_match));

    // R3: an active lookup is either a hit or a miss, never both.
    a_r3_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss));

    // R3: an idle lookup port reports nothing.
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss && lk_data == '0));

    // R4: an accepted fill answers a lookup of its address in the next cycle.
    a_r4_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=>
            (!(lk_valid && lk_addr == $past(fill_addr)) ||
             (lk_hit && lk_data == $past(fill_data))));

    // R8: after a flush nothing hits.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R7: the pointer either holds, steps by one, or returns to zero.
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rr_ptr) |-> (rr_ptr == IDX_W'($past(rr_ptr) + 1'b1) || rr_ptr == '0));
endmodule

bind taken_target_cache ttc_checker #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .LINE_W  (LINE_BYTES * 8)
) u_ttc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_addr    (lk_addr),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .lk_data    (lk_data),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .fill_data  (fill_data),
    .flush      (flush),
    .lk_match   (lk_match_vec),
    .rr_ptr     (rr_q)
);

// File: tb/taken_target_cache_bench.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// both compared against a reference model of the cache held in the bench.
module taken_target_cache_bench;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_valid = 1'b0;
    logic [31:0]  lk_addr = '0;
    logic         lk_hit, lk_miss;
    logic [127:0] lk_data;
    logic         fill_valid = 1'b0;
    logic [31:0]  fill_addr = '0;
    logic [127:0] fill_data = '0;
    logic         flush = 1'b0;

    int errors = 0;
    int checks = 0;

    // Reference model state.
    bit           m_valid [N];
    logic [31:0]  m_tag   [N];
    logic [127:0] m_data  [N];
    int           m_ptr;

    always #10 clk = ~clk;  // 50 MHz

    taken_target_cache u_taken_target_cache (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_data(lk_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .flush(flush)
    );

    // Index of the model entry holding addr, or -1.
    function automatic int m_find(input logic [31:0] addr);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == addr) return i;
        return -1;
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        m_ptr = 0;
    endfunction

    // Apply one cycle's fill/flush to the model (R5, R6, R7, R8).
    function automatic void m_apply(input bit fv, input logic [31:0] fa,
                                    input logic [127:0] fd, input bit fl);
        int slot;
        if (fl) begin
            m_clear();
            return;
        end
        if (!fv) return;
        slot = m_find(fa);
        if (slot < 0) begin
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
        end
        if (slot < 0) begin
            slot  = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        m_valid[slot] = 1'b1;
        m_tag[slot]   = fa;
        m_data[slot]  = fd;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One cycle: drive at the falling edge, check 2 ns later, then update the model.
    task automatic cyc(input bit lv, input logic [31:0] la, input bit fv,
                       input logic [31:0] fa, input logic [127:0] fd,
                       input bit fl, input string req);
        int           e;
        bit           exp_hit;
        logic [127:0] exp_data;
        @(negedge clk);
        lk_valid = lv; lk_addr = la;
        fill_valid = fv; fill_addr = fa; fill_data = fd; flush = fl;
        #2;
        e        = m_find(la);
        exp_hit  = lv && (e >= 0);
        exp_data = exp_hit ? m_data[e] : '0;
        checks++;
        if (lk_hit !== exp_hit || lk_miss !== (lv && !exp_hit) || lk_data !== exp_data) begin
            errors++;
            $display("FAIL %s addr=%h: hit=%b miss=%b data=%h expected hit=%b miss=%b data=%h",
                     req, la, lk_hit, lk_miss, lk_data, exp_hit, lv && !exp_hit, exp_data);
        end
        m_apply(fv, fa, fd, fl);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] a;
        logic [31:0] pool [24];
        void'($urandom(32'd20240611));
        m_clear();
        for (int i = 0; i < 24; i++) pool[i] = 32'h0040_1000 + 32'(i) * 32'h30;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        a = 32'h0000_8000;
        // R1: empty after reset.
        cyc(1, a, 0, '0, '0, 0, "R1 reset empty");
        cyc(0, a, 0, '0, '0, 0, "R3 idle port quiet");
        // R4: lookup together with the fill still misses, then hits.
        cyc(1, a, 1, a, 128'hA1, 0, "R4 same-cycle miss");
        cyc(1, a, 0, '0, '0, 0, "R4/R2 next-cycle hit");
        // R9: single-bit neighbours do not alias.
        cyc(1, a ^ 32'h8000_0000, 0, '0, '0, 0, "R9 top bit differs");
        cyc(1, a ^ 32'h0000_0001, 0, '0, '0, 0, "R9 low bit differs");
        // R5: refill in place.
        cyc(0, a, 1, a, 128'hA2, 0, "R5 refill");
        cyc(1, a, 0, '0, '0, 0, "R5 new line returned");
        // R6: fill the 15 free entries; the first address must survive.
        for (int i = 0; i < 15; i++)
            cyc(0, '0, 1, 32'h0000_9000 + 32'(i) * 16, 128'(i) + 128'hB0, 0, "R6 fill free");
        cyc(1, a, 0, '0, '0, 0, "R5/R6 no duplicate, A kept");
        // R7: full cache evicts entry 0, then entry 1.
        cyc(0, '0, 1, 32'h0000_A000, 128'hC0, 0, "R7 evict 0");
        cyc(1, a, 0, '0, '0, 0, "R7 entry 0 evicted");
        cyc(0, '0, 1, 32'h0000_A010, 128'hC1, 0, "R7 evict 1");
        cyc(1, 32'h0000_9000, 0, '0, '0, 0, "R7 entry 1 evicted");
        cyc(1, 32'h0000_9010, 0, '0, '0, 0, "R7 entry 2 kept");
        // R8: flush beats a simultaneous fill.
        cyc(1, 32'h0000_A000, 1, 32'h0000_A020, 128'hC2, 1, "R8 flush cycle");
        cyc(1, 32'h0000_A000, 0, '0, '0, 0, "R8 flushed entry misses");
        cyc(1, 32'h0000_A020, 0, '0, '0, 0, "R8 fill during flush dropped");
        cyc(0, '0, 1, 32'h0000_E000, 128'hE0, 0, "R8 refill after flush");
        cyc(1, 32'h0000_E000, 0, '0, '0, 0, "R8 usable after flush");

        // Random traffic over a pool larger than the cache (R2, R4-R8).
        for (int n = 0; n < 4000; n++) begin
            bit lv, fv, fl;
            lv = ($urandom_range(9) < 7);
            fv = ($urandom_range(9) < 3);
            fl = ($urandom_range(199) == 0);
            cyc(lv, pool[$urandom_range(23)], fv, pool[$urandom_range(23)],
                rnd128(), fl, "R2/R7 random");
        end
        summary();
    end
endmodule